// File: doc/BRIEF.md
# Error-Correcting SRAM Wrapper with Read-Modify-Write

This block puts a single-port SRAM array behind a simple bus port and guards every stored word with a single-error-correct, double-error-detect code. By default one 64-bit doubleword is one protected unit with 8 check bits. With `SPLIT` set, the doubleword becomes two independent 32-bit units, the lower (even) and the upper (odd) word, and each carries its own 7 check bits. Reads correct any single flipped bit in the returned data without adding a cycle, and they flag words that have two flipped bits.

Writes use byte enables. A write that covers every protected unit it touches is encoded and stored in one cycle. A write that covers only part of a unit becomes an internal read-modify-write: the block reads the word, checks it, merges the new bytes over the corrected old ones, re-encodes the result and writes it back. This costs one stall cycle. If the old word cannot be corrected, the write is dropped. The block reports each corrected or uncorrectable event as a one-cycle pulse together with the unit address and the syndrome, for use by an external status collector. A test hook XORs a mask into the stored bits of a full write so that faults can be planted.

Top module: `secded_sram`

## Requirements
- R1: A write whose byte enables are all-ones or all-zeros in each protected unit is stored in the cycle it is accepted. `ready` stays high in the following cycle.
- R2: A read accepted at one clock edge presents `rvalid` and the 64-bit data in the cycle that follows. `rdata` is the corrected contents.
- R3: A write whose byte enables cover only part of some protected unit drives `ready` low for exactly one cycle after it is accepted. Afterwards the enabled bytes hold the new data and all other bytes keep their old values.
- R4: A single flipped bit is corrected in `rdata`. In the check cycle `ce_o` pulses, `err_addr` = {doubleword address, unit index}, and `err_syn` = {1, position}. Data bit j has as its position the (j+1)-th integer ≥ 3 that is not a power of two, so bit 0 is 3 and bit 5 is 10. Hamming check bit k has position 2^k.
- R5: Two flipped bits in one unit pulse `ue_o` and leave `rdata` uncorrected. `err_syn` = {0, XOR of the two positions}.
- R6: If the read phase of a read-modify-write finds an uncorrectable unit among those it writes, `ue_o` and `wr_err_o` pulse together in the stall cycle and the stored word stays unchanged.
- R7: If the read phase of a read-modify-write finds a correctable error, `ce_o` pulses and the word written back is the corrected old data merged with the new bytes, with fresh check bits.
- R8: On a full write (R1), `flip_mask` is XORed into the stored word. Data occupies stored bits [63:0]. Unit u's check field sits at [64+u·C +: C] (C = 8 unsplit, 7 split), with the overall parity bit as its top bit. On a read-modify-write the mask has no effect.
- R9: In split mode each 32-bit half is encoded on its own. A write that fills one half and leaves the other disabled does not stall and preserves the other half. Errors in the upper half report unit index 1.
- R10: `ce_o` and `ue_o` are never high together. If one check cycle sees an uncorrectable unit and a correctable unit, only `ue_o` pulses, and the address and syndrome are those of the uncorrectable unit.
- R11: A request presented while `ready` is low is ignored and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request strobe, taken when `ready` is high |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Doubleword address |
| be | input | 8 | Byte enables for writes, bit b covers data bits [8b+7:8b] |
| wdata | input | 64 | Write data, lane aligned |
| flip_mask | input | SW | Fault-planting XOR mask for full writes |
| ready | output | 1 | Low during the read-modify-write stall cycle |
| rvalid | output | 1 | Read data valid |
| rdata | output | 64 | Corrected read data |
| ce_o | output | 1 | Corrected-error pulse |
| ue_o | output | 1 | Uncorrectable-error pulse |
| wr_err_o | output | 1 | Read-modify-write aborted pulse |
| err_addr | output | ADDR_W+1 | {doubleword address, unit index} of the reported unit |
| err_syn | output | C | Syndrome of the reported unit |

## Verification
The hardest case to reach from the ports is a byte write that lands on a word which already holds an uncorrectable fault. A fault cannot appear on its own in a clean array. The bench first plants two flipped bits with a full write that carries `flip_mask`. It then issues a single-byte write to the same address, so the internal read phase meets the corrupted word. A following read shows that the plain XOR-damaged data is still there and the new byte was not merged in. The same steps with a single flipped bit show the scrub-on-merge path. In split mode, two faults placed in different halves of one word exercise the reporting priority.

// File: rtl/secded_pkg.sv
// Shared helpers for the error-correcting SRAM wrapper.
// Assumes at most 64 data bits per protected unit.
package secded_pkg;

    // Number of Hamming check bits (overall parity excluded) for k data bits.
    function automatic int hbits(input int k);
        int res;
        res = 0;
        for (int r = 1; r < 16; r++) begin
            if (res == 0 && (1 << r) >= k + r + 1) res = r;
        end
        return res;
    endfunction

    // Code positions of data bits: the integers >= 3 that are not powers of two.
    function automatic logic [511:0] pos_table();
        logic [511:0] tab;
        int n;
        tab = '0;
        n = 0;
        for (int q = 3; q < 128; q++) begin
            if ((q & (q - 1)) != 0 && n < 64) begin
                tab[n*8 +: 8] = 8'(q);
                n++;
            end
        end
        return tab;
    endfunction

endpackage

// File: rtl/ecc_enc.sv
// Check-bit generator for one protected unit of K data bits.
// Output is {overall parity, Hamming bits}. The overall bit makes the whole
// codeword even.
module ecc_enc #(
    parameter int K = 64,
    localparam int HB = secded_pkg::hbits(K),
    localparam int R = HB + 1
) (
    input  logic [K-1:0] d,
    output logic [R-1:0] chk
);
    localparam logic [511:0] PT = secded_pkg::pos_table();

    logic [HB-1:0] h;

    // Fold each data bit into the Hamming bits its position selects.
    always_comb begin
        h = '0;
        for (int j = 0; j < K; j++) begin
            for (int b = 0; b < HB; b++) begin
                if (PT[j*8 + b]) h[b] = h[b] ^ d[j];
            end
        end
        chk = {(^d) ^ (^h), h};
    end
endmodule

// File: rtl/ecc_dec.sv
// Syndrome decoder and corrector for one protected unit.
// Assumes the check layout produced by ecc_enc. Purely combinational.
module ecc_dec #(
    parameter int K = 64,
    localparam int HB = secded_pkg::hbits(K),
    localparam int R = HB + 1
) (
    input  logic [K-1:0] d,
    input  logic [R-1:0] c,
    output logic [K-1:0] dq,
    output logic [R-1:0] syn,
    output logic         ce,
    output logic         ue
);
    localparam logic [511:0] PT = secded_pkg::pos_table();

    logic [R-1:0]  rc;
    logic [HB-1:0] s;
    logic          p;

    ecc_enc #(.K(K)) u_re (.d(d), .chk(rc));

    // Form the syndrome, classify it and flip the addressed data bit.
    always_comb begin
        s   = rc[HB-1:0] ^ c[HB-1:0];
        p   = ^(rc ^ c);
        syn = {p, s};
        ce  = p;
        ue  = !p && (s != '0);
        for (int j = 0; j < K; j++) begin
            dq[j] = d[j] ^ (p && (s == PT[j*8 +: HB]));
        end
    end
endmodule

// File: rtl/sram_array.sv
// Single-port storage array with a bit write mask and a registered read.
// Contents are not reset; read data is held until the next read.
module sram_array #(
    parameter int DEPTH = 16,
    parameter int W = 72,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wmask,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // Masked write and registered read, one port.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= (mem[addr] & ~wmask) | (wdata & wmask);
        if (re) rdata <= mem[addr];
    end
endmodule

// File: rtl/secded_sram.sv
// Error-correcting SRAM wrapper. A doubleword is one 64+8 unit, or two 32+7
// units when SPLIT is set. Full-unit writes go straight to the array.
// Partial-unit writes stall one cycle for read-modify-write. Assumes the
// requester holds off while ready is low.
module secded_sram #(
    parameter int DEPTH = 16,
    parameter bit SPLIT = 1'b0,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int NU = SPLIT ? 2 : 1,
    localparam int UK = 64 / NU,
    localparam int R = secded_pkg::hbits(UK) + 1,
    localparam int SW = 64 + NU * R
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        be,
    input  logic [63:0]       wdata,
    input  logic [SW-1:0]     flip_mask,
    output logic              ready,
    output logic              rvalid,
    output logic [63:0]       rdata,
    output logic              ce_o,
    output logic              ue_o,
    output logic              wr_err_o,
    output logic [ADDR_W:0]   err_addr,
    output logic [R-1:0]      err_syn
);
    localparam int UBE = 8 / NU;

    logic              rd_q, rmw_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        be_q;
    logic [63:0]       wdata_q;

    logic [NU-1:0]     part_u, chk_u, ce_u, ue_u, wen_u;
    logic              partial, accept, rd_acc, fw_acc, pw_acc;
    logic [SW-1:0]     arr_q, arr_wdata, arr_wmask;
    logic [63:0]       corr, merged, enc_in;
    logic [R-1:0]      syn_u [NU];
    logic [R-1:0]      chk_new [NU];
    logic              ue_any, ce_any, found, pick, arr_we, arr_re;
    logic [ADDR_W-1:0] arr_addr;
    logic [7:0]        be_src;

    // Classify incoming byte enables per unit.
    always_comb begin
        for (int u = 0; u < NU; u++) begin
            part_u[u] = (|be[u*UBE +: UBE]) && !(&be[u*UBE +: UBE]);
        end
        partial = |part_u;
        accept  = req && ready;
        rd_acc  = accept && !we;
        fw_acc  = accept && we && !partial;
        pw_acc  = accept && we && partial;
    end

    // Request register: remembers the pending read or read-modify-write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= 1'b0;
            rmw_q <= 1'b0;
        end else begin
            rd_q  <= rd_acc;
            rmw_q <= pw_acc;
        end
        if (accept) begin
            addr_q  <= addr;
            be_q    <= be;
            wdata_q <= wdata;
        end
    end

    assign ready = !rmw_q;

    // Per-unit decoders and encoders.
    for (genvar u = 0; u < NU; u++) begin : g_unit
        ecc_dec #(.K(UK)) u_dec (
            .d   (arr_q[u*UK +: UK]),
            .c   (arr_q[64 + u*R +: R]),
            .dq  (corr[u*UK +: UK]),
            .syn (syn_u[u]),
            .ce  (ce_u[u]),
            .ue  (ue_u[u])
        );
        ecc_enc #(.K(UK)) u_enc (
            .d   (enc_in[u*UK +: UK]),
            .chk (chk_new[u])
        );
    end

    // Byte merge of new data over the corrected old word.
    always_comb begin
        for (int b = 0; b < 8; b++) begin
            merged[b*8 +: 8] = be_q[b] ? wdata_q[b*8 +: 8] : corr[b*8 +: 8];
        end
        enc_in = rmw_q ? merged : wdata;
    end

    // Which units are checked this cycle, and which one is reported.
    always_comb begin
        ue_any = 1'b0;
        ce_any = 1'b0;
        found  = 1'b0;
        pick   = 1'b0;
        for (int u = 0; u < NU; u++) begin
            chk_u[u] = rd_q || (rmw_q && (|be_q[u*UBE +: UBE]));
            ue_any = ue_any | (chk_u[u] & ue_u[u]);
            ce_any = ce_any | (chk_u[u] & ce_u[u]);
        end
        for (int u = 0; u < NU; u++) begin
            if (!found && chk_u[u] && ue_u[u]) begin
                pick  = 1'(u);
                found = 1'b1;
            end
        end
        for (int u = 0; u < NU; u++) begin
            if (!found && chk_u[u] && ce_u[u]) begin
                pick  = 1'(u);
                found = 1'b1;
            end
        end
    end

    // Response and error-report outputs.
    always_comb begin
        rvalid   = rd_q;
        rdata    = corr;
        ue_o     = ue_any;
        ce_o     = ce_any && !ue_any;
        wr_err_o = rmw_q && ue_any;
        err_addr = {addr_q, (NU == 2) ? pick : 1'b0};
        err_syn  = (ue_any || ce_any) ? syn_u[pick] : '0;
    end

    // Array write data, mask and control.
    always_comb begin
        be_src    = rmw_q ? be_q : be;
        arr_wdata[63:0] = enc_in;
        arr_wmask = '0;
        for (int u = 0; u < NU; u++) begin
            wen_u[u] = |be_src[u*UBE +: UBE];
            arr_wdata[64 + u*R +: R] = chk_new[u];
            arr_wmask[u*UK +: UK]    = {UK{wen_u[u]}};
            arr_wmask[64 + u*R +: R] = {R{wen_u[u]}};
        end
        if (fw_acc) arr_wdata = arr_wdata ^ flip_mask;
        arr_we   = fw_acc || (rmw_q && !ue_any);
        arr_re   = rd_acc || pw_acc;
        arr_addr = rmw_q ? addr_q : addr;
    end

    sram_array #(.DEPTH(DEPTH), .W(SW)) u_arr (
        .clk   (clk),
        .we    (arr_we),
        .re    (arr_re),
        .addr  (arr_addr),
        .wmask (arr_wmask),
        .wdata (arr_wdata),
        .rdata (arr_q)
    );

    // R3
    rmw_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && ready && partial) |=> !ready);
    // R3
    stall_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> ready);
    // R2
    rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && ready) |=> rvalid);
    // R10
    ce_ue_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ce_o && ue_o));
    // R6
    wr_err_ue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err_o |-> (ue_o && !ready));
    // R11
    no_resp_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> !rvalid);
endmodule

// File: tb/tb_secded_sram.sv
module tb_secded_sram;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Unsplit instance
    logic        req = 0, we = 0;
    logic [3:0]  addr = 0;
    logic [7:0]  be = 0;
    logic [63:0] wdata = 0;
    logic [71:0] fmask = 0;
    logic        ready, rvalid, ce_o, ue_o, wr_err_o;
    logic [63:0] rdata;
    logic [4:0]  err_addr;
    logic [7:0]  err_syn;

    secded_sram #(.DEPTH(16), .SPLIT(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .be(be),
        .wdata(wdata), .flip_mask(fmask), .ready(ready), .rvalid(rvalid),
        .rdata(rdata), .ce_o(ce_o), .ue_o(ue_o), .wr_err_o(wr_err_o),
        .err_addr(err_addr), .err_syn(err_syn));

    // Split instance
    logic        s_req = 0, s_we = 0;
    logic [3:0]  s_addr = 0;
    logic [7:0]  s_be = 0;
    logic [63:0] s_wdata = 0;
    logic [77:0] s_fmask = 0;
    logic        s_ready, s_rvalid, s_ce, s_ue, s_wr_err;
    logic [63:0] s_rdata;
    logic [4:0]  s_err_addr;
    logic [6:0]  s_err_syn;

    secded_sram #(.DEPTH(16), .SPLIT(1'b1)) dut_split (
        .clk(clk), .rst_n(rst_n), .req(s_req), .we(s_we), .addr(s_addr), .be(s_be),
        .wdata(s_wdata), .flip_mask(s_fmask), .ready(s_ready), .rvalid(s_rvalid),
        .rdata(s_rdata), .ce_o(s_ce), .ue_o(s_ue), .wr_err_o(s_wr_err),
        .err_addr(s_err_addr), .err_syn(s_err_syn));

    function automatic int exp_pos(input int j);
        int n = 0;
        int res = 0;
        for (int q = 3; q < 128; q++) begin
            if ((q & (q - 1)) != 0) begin
                if (n == j) res = q;
                n++;
            end
        end
        return res;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Present one request on the unsplit port; return at the check cycle.
    task automatic op(input bit w, input int a, input logic [7:0] b,
                      input logic [63:0] d, input logic [71:0] m);
        @(negedge clk);
        req = 1; we = w; addr = 4'(a); be = b; wdata = d; fmask = m;
        @(negedge clk);
        req = 0; fmask = '0;
    endtask

    task automatic s_op(input bit w, input int a, input logic [7:0] b,
                        input logic [63:0] d, input logic [77:0] m);
        @(negedge clk);
        s_req = 1; s_we = w; s_addr = 4'(a); s_be = b; s_wdata = d; s_fmask = m;
        @(negedge clk);
        s_req = 0; s_fmask = '0;
    endtask

    task automatic t_reset();
        check(ready == 1 && rvalid == 0, "R2 reset idle", {62'd0, ready, rvalid}, 64'h2);
        check(ce_o == 0 && ue_o == 0 && wr_err_o == 0, "R10 reset quiet",
              {61'd0, ce_o, ue_o, wr_err_o}, 64'h0);
    endtask

    task automatic t_full();
        op(1, 3, 8'hFF, 64'h0123_4567_89AB_CDEF, '0);
        check(ready == 1, "R1 no stall", {63'd0, ready}, 64'd1);
        op(0, 3, 8'h00, '0, '0);
        check(rvalid && rdata == 64'h0123_4567_89AB_CDEF && !ce_o && !ue_o,
              "R2 readback A", rdata, 64'h0123_4567_89AB_CDEF);
        op(1, 4, 8'hFF, 64'hFFFF_0000_A5A5_5A5A, '0);
        op(0, 4, 8'h00, '0, '0);
        check(rvalid && rdata == 64'hFFFF_0000_A5A5_5A5A, "R2 readback B",
              rdata, 64'hFFFF_0000_A5A5_5A5A);
    endtask

    task automatic t_partial();
        op(1, 3, 8'h04, 64'h0000_0000_00EE_0000, '0);
        check(ready == 0, "R3 stall", {63'd0, ready}, 64'd0);
        op(0, 3, 8'h00, '0, '0);
        check(rdata == 64'h0123_4567_89EE_CDEF, "R3 byte merge", rdata, 64'h0123_4567_89EE_CDEF);
        op(1, 3, 8'h30, 64'h0000_BEEF_0000_0000, '0);
        check(ready == 0, "R3 stall 16b", {63'd0, ready}, 64'd0);
        op(0, 3, 8'h00, '0, '0);
        check(rdata == 64'h0123_BEEF_89EE_CDEF, "R3 half merge", rdata, 64'h0123_BEEF_89EE_CDEF);
    endtask

    task automatic t_single();
        logic [7:0] es;
        es = {1'b1, 7'(exp_pos(5))};
        op(1, 5, 8'hFF, 64'hCAFE_F00D_1234_5678, 72'd1 << 5);
        op(0, 5, 8'h00, '0, '0);
        check(ce_o && !ue_o && rdata == 64'hCAFE_F00D_1234_5678, "R4 corrected data",
              rdata, 64'hCAFE_F00D_1234_5678);
        check(err_syn == es && err_addr == 5'd10, "R4 syndrome/addr",
              {51'd0, err_addr, err_syn}, {51'd0, 5'd10, es});
        op(1, 6, 8'hFF, 64'h1111_2222_3333_4444, 72'd1 << 64);
        op(0, 6, 8'h00, '0, '0);
        check(ce_o && rdata == 64'h1111_2222_3333_4444 && err_syn == 8'h81,
              "R8 check-bit flip", {48'd0, 7'd0, ce_o, err_syn}, {48'd0, 8'h01, 8'h81});
        op(0, 6, 8'h00, '0, '0);
        check(ce_o == 1, "R4 fault persists on read", {63'd0, ce_o}, 64'd1);
    endtask

    task automatic t_double();
        logic [7:0] es;
        es = {1'b0, 7'(exp_pos(0) ^ exp_pos(1))};
        op(1, 7, 8'hFF, 64'h0000_0000_0000_0000, 72'h3);
        op(0, 7, 8'h00, '0, '0);
        check(ue_o && !ce_o && rdata == 64'h3, "R5 ue flag/raw data", rdata, 64'h3);
        check(err_syn == es, "R5 syndrome", {56'd0, err_syn}, {56'd0, es});
    endtask

    task automatic t_rmw_ue();
        op(1, 7, 8'h80, 64'h5500_0000_0000_0000, '0);
        check(ue_o && wr_err_o && !ready, "R6 abort report",
              {61'd0, ue_o, wr_err_o, ready}, 64'h6);
        op(0, 7, 8'h00, '0, '0);
        check(ue_o && rdata == 64'h3, "R6 word unchanged", rdata, 64'h3);
    endtask

    task automatic t_rmw_ce();
        op(1, 8, 8'hFF, 64'h0000_0000_0000_0000, 72'd1 << 40);
        op(1, 8, 8'h01, 64'h0000_0000_0000_0077, 72'h3);
        check(ce_o && !wr_err_o && !ue_o, "R7 ce in rmw", {61'd0, ce_o, ue_o, wr_err_o}, 64'h4);
        op(0, 8, 8'h00, '0, '0);
        check(!ce_o && !ue_o && rdata == 64'h77, "R7 scrubbed merge / R8 mask ignored",
              rdata, 64'h77);
    endtask

    task automatic t_ignore();
        op(1, 4, 8'h01, 64'h11, '0);
        req = 1; we = 0; addr = 4'd4;
        @(negedge clk);
        req = 0;
        check(rvalid == 0, "R11 request ignored", {63'd0, rvalid}, 64'd0);
        op(0, 4, 8'h00, '0, '0);
        check(rdata == 64'hFFFF_0000_A5A5_5A11, "R11 state intact", rdata, 64'hFFFF_0000_A5A5_5A11);
    endtask

    task automatic t_split();
        s_op(1, 2, 8'hFF, 64'hAAAA_BBBB_CCCC_DDDD, '0);
        s_op(1, 2, 8'h0F, 64'h0000_0000_1234_5678, '0);
        check(s_ready == 1, "R9 half write no stall", {63'd0, s_ready}, 64'd1);
        s_op(0, 2, 8'h00, '0, '0);
        check(s_rdata == 64'hAAAA_BBBB_1234_5678 && !s_ce && !s_ue, "R9 other half kept",
              s_rdata, 64'hAAAA_BBBB_1234_5678);
        s_op(1, 2, 8'h10, 64'h0000_0099_0000_0000, '0);
        check(s_ready == 0, "R3 split partial stall", {63'd0, s_ready}, 64'd0);
        s_op(0, 2, 8'h00, '0, '0);
        check(s_rdata == 64'hAAAA_BB99_1234_5678, "R3 split merge", s_rdata, 64'hAAAA_BB99_1234_5678);
        s_op(1, 9, 8'hFF, 64'h0, 78'h3 << 32);
        s_op(0, 9, 8'h00, '0, '0);
        check(s_ue && s_err_addr == 5'd19 && s_err_syn == 7'(exp_pos(0) ^ exp_pos(1)),
              "R9 upper half ue", {57'd0, s_err_addr, 2'd0}, {57'd0, 5'd19, 2'd0});
        s_op(1, 10, 8'hFF, 64'h0, (78'h3 << 32) | 78'h1);
        s_op(0, 10, 8'h00, '0, '0);
        check(s_ue && !s_ce && s_err_addr == 5'd21, "R10 ue outranks ce",
              {57'd0, s_err_addr, s_ue, s_ce}, {57'd0, 5'd21, 2'b10});
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full();
        t_partial();
        t_single();
        t_double();
        t_rmw_ue();
        t_rmw_ce();
        t_ignore();
        t_split();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule